// File: doc/BRIEF.md
# Host-Side Mailbox Buffer for an 8-bit Slave Controller

This block sits between an external host bus and the core of an 8-bit slave controller. It holds one byte travelling host-to-core (the input buffer), one byte travelling core-to-host (the output buffer), and an 8-bit status register. The host reaches it with active-low chip select, read and write strobes and an address bit that separates data from commands. The bidirectional data bus is split into an input bus, an output bus and an output enable. The core drives single-cycle strobes that consume the input byte, post an output byte, load the user-defined status nibble and set the two general flags F0 and F1.

All host strobes act on their trailing edge. The internal handshake flags move only after a host access has ended, never while it is in progress. While the host reads the status register, the register is frozen. Any core update that arrives during that time is held and applied in the first cycle after the read ends. There are also three optional pin functions, all off after reset: an output-full interrupt pin, an input-ready interrupt pin (the inverse of the input-full flag), and a DMA request/acknowledge pair in which the acknowledge input acts as a chip select for the buffers.

Top module: `hb_host_buffer`

## Requirements
- R1: After reset the status register, both buffers, the output enable and all three pin outputs are 0.
- R2: A user-status load copies its 4-bit value into status bits 7..4 and leaves status bits 3..0 as they were.
- R3: A selected host write latches the data byte. In the cycle after the write strobe rises, that byte appears in the input buffer, IBF (status bit 1) is 1 and F1 (status bit 3) equals the A0 value of the write (1 = command, 0 = data). Nothing changes while the strobe is still low.
- R4: A core read strobe clears IBF. A core write stores its byte in the output buffer at once and sets OBF (status bit 0). If a core read strobe and the end of a host write fall in the same cycle, IBF ends at 1. If a core write and the end of a host data read fall in the same cycle, OBF ends at 1.
- R5: The output enable is 1 exactly while a selected read strobe is low. A read with A0=0 returns the output buffer and clears OBF in the cycle after the strobe rises. A read with A0=1 returns the status register and clears nothing.
- R6: While a selected status read is in progress, the status register does not change. Core status updates received during it (IBF clear, OBF set, user load, F0/F1 writes) take effect in the cycle after the read strobe rises. A later update of the same kind overrides an earlier one.
- R7: The core sets F0 (status bit 2) and F1 to a given value with a write strobe each.
- R8: Once flag pins are enabled, the output-full pin equals OBF while its port bit is 1 and is 0 otherwise. The input-ready pin equals NOT IBF while its port bit is 1 and is 0 otherwise.
- R9: Once DMA is enabled, a request-set strobe raises the DMA request. The request drops after a host access made under acknowledge ends, or when DMA is enabled again (which wins over a same-cycle set).
- R10: Once DMA is enabled, an active-low acknowledge selects the buffers for host reads and writes without chip select.
- R11: Before their enable strobes, the flag pins stay 0 whatever their port bits are, and the acknowledge input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | 0 = data/output buffer, 1 = command/status |
| host_dack_n | input | 1 | DMA acknowledge, active low |
| host_din | input | DW | Host write data |
| host_dout | output | DW | Host read data |
| host_doe | output | 1 | Drive enable for host_dout |
| cpu_ibuf_rd | input | 1 | Core consumes the input buffer |
| cpu_ibuf_data | output | DW | Input buffer contents |
| cpu_obuf_wr | input | 1 | Core posts a byte to the output buffer |
| cpu_obuf_data | input | DW | Byte posted by the core |
| cpu_sts_ld | input | 1 | Load the user status nibble |
| cpu_sts_user | input | DW-4 | New status bits 7..4 |
| cpu_f0_wr | input | 1 | Write F0 |
| cpu_f0_val | input | 1 | Value for F0 |
| cpu_f1_wr | input | 1 | Write F1 |
| cpu_f1_val | input | 1 | Value for F1 |
| cpu_flags_en | input | 1 | Turn on flag pin functions (sticky until reset) |
| cpu_dma_en | input | 1 | Turn on DMA functions (sticky), clears request |
| cpu_drq_set | input | 1 | Raise DMA request |
| port_obf_bit | input | 1 | Port latch bit gating the output-full pin |
| port_ibf_bit | input | 1 | Port latch bit gating the input-ready pin |
| pin_obf | output | 1 | Output-full interrupt pin |
| pin_ibf | output | 1 | Input-ready interrupt pin |
| pin_drq | output | 1 | DMA request pin |
| status | output | DW | Status register |

## Verification
A wrong flag would appear on the status port one cycle after the edge that moved it. It would also appear on the interrupt pins in that same cycle, and on the host bus at the next status read. A lost or misapplied deferred update shows as a status mismatch in the first cycle after a status read ends. A mis-latched command/data bit shows up as a wrong F1 right after the write ends. The bench model is compared against every observable output on every cycle, so any such divergence is reported in the cycle it appears.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_LOW_BITS = 4;

  // pin value of the output-full interrupt function
  function automatic logic hb_obf_pin(input logic fn_on, input logic latch, input logic obf);
    return fn_on & latch & obf;
  endfunction

  // pin value of the input-ready function: inverse of the full flag
  function automatic logic hb_ibf_pin(input logic fn_on, input logic latch, input logic ibf);
    return fn_on & latch & ~ibf;
  endfunction

  // low nibble layout: F1, F0, IBF, OBF from bit 3 down to bit 0
  function automatic logic [HB_LOW_BITS-1:0] hb_low(input logic f1, input logic f0,
                                                   input logic ibf, input logic obf);
    return {f1, f0, ibf, obf};
  endfunction
endpackage

// File: rtl/hb_host_port.sv
module hb_host_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic          dack_n,
  input  logic [DW-1:0] din,
  input  logic          dma_mode,
  output logic          rd_act,
  output logic          lock,
  output logic          wr_done,
  output logic          wr_cmd,
  output logic [DW-1:0] wr_byte,
  output logic          rd_data_done,
  output logic          dack_done
);
  logic via_dack, sel, wr_act, rd_done;
  logic rd_q, wr_q, a0_rq, a0_wq, dack_q;
  logic [DW-1:0] byte_q;

  assign via_dack = dma_mode & ~dack_n;
  assign sel      = ~cs_n | via_dack;
  assign rd_act   = sel & ~rd_n;
  assign wr_act   = sel & ~wr_n;
  assign lock     = rd_act & a0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0; wr_q <= 1'b0; a0_rq <= 1'b0; a0_wq <= 1'b0;
      dack_q <= 1'b0; byte_q <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (rd_act) a0_rq <= a0;
      if (wr_act) begin
        a0_wq  <= a0;
        byte_q <= din;
      end
      if (rd_act | wr_act) dack_q <= via_dack;
    end
  end

  assign rd_done      = rd_q & ~rd_act;
  assign wr_done      = wr_q & ~wr_act;
  assign rd_data_done = rd_done & ~a0_rq;
  assign wr_cmd       = a0_wq;
  assign wr_byte      = byte_q;
  assign dack_done    = (rd_done | wr_done) & dack_q;
endmodule

// File: rtl/hb_status.sv
module hb_status #(
  parameter int UW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          host_wr_done,
  input  logic          host_wr_cmd,
  input  logic          host_rd_data_done,
  input  logic          cpu_ibuf_rd,
  input  logic          cpu_obuf_wr,
  input  logic          cpu_sts_ld,
  input  logic [UW-1:0] cpu_sts_user,
  input  logic          cpu_f0_wr,
  input  logic          cpu_f0_val,
  input  logic          cpu_f1_wr,
  input  logic          cpu_f1_val,
  output logic [UW-1:0] user,
  output logic          f1,
  output logic          f0,
  output logic          ibf,
  output logic          obf
);
  logic p_ibf_clr, p_obf_set, p_user_v, p_f0_v, p_f0, p_f1_v, p_f1;
  logic [UW-1:0] p_user;
  logic eff_ibf_clr, eff_obf_set, eff_user_v, eff_f0_v, eff_f0, eff_f1_v, eff_f1;
  logic [UW-1:0] eff_user;

  // held requests merged with this cycle's strobes; newer data wins
  always_comb begin
    eff_ibf_clr = p_ibf_clr | cpu_ibuf_rd;
    eff_obf_set = p_obf_set | cpu_obuf_wr;
    eff_user_v  = p_user_v | cpu_sts_ld;
    eff_user    = cpu_sts_ld ? cpu_sts_user : p_user;
    eff_f0_v    = p_f0_v | cpu_f0_wr;
    eff_f0      = cpu_f0_wr ? cpu_f0_val : p_f0;
    eff_f1_v    = p_f1_v | cpu_f1_wr;
    eff_f1      = cpu_f1_wr ? cpu_f1_val : p_f1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_ibf_clr <= 1'b0; p_obf_set <= 1'b0; p_user_v <= 1'b0; p_user <= '0;
      p_f0_v <= 1'b0; p_f0 <= 1'b0; p_f1_v <= 1'b0; p_f1 <= 1'b0;
      user <= '0; f1 <= 1'b0; f0 <= 1'b0; ibf <= 1'b0; obf <= 1'b0;
    end else if (lock) begin
      p_ibf_clr <= eff_ibf_clr;
      p_obf_set <= eff_obf_set;
      p_user_v  <= eff_user_v;
      p_user    <= eff_user;
      p_f0_v    <= eff_f0_v;
      p_f0      <= eff_f0;
      p_f1_v    <= eff_f1_v;
      p_f1      <= eff_f1;
      if (host_wr_done) begin
        ibf <= 1'b1;
        f1  <= host_wr_cmd;
      end
    end else begin
      p_ibf_clr <= 1'b0; p_obf_set <= 1'b0; p_user_v <= 1'b0;
      p_f0_v <= 1'b0; p_f1_v <= 1'b0;
      if (host_wr_done)     ibf <= 1'b1;
      else if (eff_ibf_clr) ibf <= 1'b0;
      if (eff_obf_set)            obf <= 1'b1;
      else if (host_rd_data_done) obf <= 1'b0;
      if (eff_user_v) user <= eff_user;
      if (eff_f0_v)   f0 <= eff_f0;
      if (host_wr_done)  f1 <= host_wr_cmd;
      else if (eff_f1_v) f1 <= eff_f1;
    end
  end

  AST_IBF_ON_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_done |=> ibf); // R3
  AST_F1_FOLLOWS_A0: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_done |=> (f1 == $past(host_wr_cmd))); // R3
  AST_IBF_CLEARED_BY_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ibuf_rd && !lock && !host_wr_done) |=> !ibf); // R4
  AST_OBF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data_done && !lock && !eff_obf_set) |=> !obf); // R5
  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !host_wr_done) |=> $stable({user, f1, f0, ibf, obf})); // R6
endmodule

// File: rtl/hb_pinfunc.sv
module hb_pinfunc (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_flags_en,
  input  logic cpu_dma_en,
  input  logic cpu_drq_set,
  input  logic port_obf_bit,
  input  logic port_ibf_bit,
  input  logic ibf,
  input  logic obf,
  input  logic dack_done,
  output logic dma_mode,
  output logic pin_obf,
  output logic pin_ibf,
  output logic pin_drq
);
  import hb_pkg::*;
  logic flags_mode, drq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_mode <= 1'b0;
      dma_mode   <= 1'b0;
      drq        <= 1'b0;
    end else begin
      if (cpu_flags_en) flags_mode <= 1'b1;
      if (cpu_dma_en)   dma_mode   <= 1'b1;
      if (cpu_dma_en)                    drq <= 1'b0;
      else if (dma_mode && cpu_drq_set)  drq <= 1'b1;
      else if (dack_done)                drq <= 1'b0;
    end
  end

  assign pin_obf = hb_obf_pin(flags_mode, port_obf_bit, obf);
  assign pin_ibf = hb_ibf_pin(flags_mode, port_ibf_bit, ibf);
  assign pin_drq = drq;

  AST_DRQ_ONLY_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drq |-> dma_mode); // R9
  AST_DRQ_DROPS_ON_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dma_en |=> !pin_drq); // R9
  AST_DRQ_DROPS_AFTER_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_done && !cpu_drq_set) |=> !pin_drq); // R9
  AST_FLAG_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_mode |-> (!pin_obf && !pin_ibf)); // R11
endmodule

// File: rtl/hb_host_buffer.sv
module hb_host_buffer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_a0,
  input  logic          host_dack_n,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  input  logic          cpu_ibuf_rd,
  output logic [DW-1:0] cpu_ibuf_data,
  input  logic          cpu_obuf_wr,
  input  logic [DW-1:0] cpu_obuf_data,
  input  logic          cpu_sts_ld,
  input  logic [DW-5:0] cpu_sts_user,
  input  logic          cpu_f0_wr,
  input  logic          cpu_f0_val,
  input  logic          cpu_f1_wr,
  input  logic          cpu_f1_val,
  input  logic          cpu_flags_en,
  input  logic          cpu_dma_en,
  input  logic          cpu_drq_set,
  input  logic          port_obf_bit,
  input  logic          port_ibf_bit,
  output logic          pin_obf,
  output logic          pin_ibf,
  output logic          pin_drq,
  output logic [DW-1:0] status
);
  import hb_pkg::*;
  localparam int UW = DW - HB_LOW_BITS;

  // named internal events
  logic ev_rd_act, ev_lock, ev_wr_done, ev_wr_cmd, ev_rd_data_done, ev_dack_done;
  logic dma_mode;
  logic [DW-1:0] wr_byte, ibuf_q, obuf_q;
  logic [UW-1:0] user;
  logic f1, f0, ibf, obf;

  hb_host_port #(.DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n), .cs_n(host_cs_n), .rd_n(host_rd_n), .wr_n(host_wr_n),
    .a0(host_a0), .dack_n(host_dack_n), .din(host_din), .dma_mode(dma_mode),
    .rd_act(ev_rd_act), .lock(ev_lock), .wr_done(ev_wr_done), .wr_cmd(ev_wr_cmd),
    .wr_byte(wr_byte), .rd_data_done(ev_rd_data_done), .dack_done(ev_dack_done)
  );

  hb_status #(.UW(UW)) u_status (
    .clk(clk), .rst_n(rst_n), .lock(ev_lock), .host_wr_done(ev_wr_done),
    .host_wr_cmd(ev_wr_cmd), .host_rd_data_done(ev_rd_data_done),
    .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_obuf_wr(cpu_obuf_wr), .cpu_sts_ld(cpu_sts_ld),
    .cpu_sts_user(cpu_sts_user), .cpu_f0_wr(cpu_f0_wr), .cpu_f0_val(cpu_f0_val),
    .cpu_f1_wr(cpu_f1_wr), .cpu_f1_val(cpu_f1_val),
    .user(user), .f1(f1), .f0(f0), .ibf(ibf), .obf(obf)
  );

  hb_pinfunc u_pins (
    .clk(clk), .rst_n(rst_n), .cpu_flags_en(cpu_flags_en), .cpu_dma_en(cpu_dma_en),
    .cpu_drq_set(cpu_drq_set), .port_obf_bit(port_obf_bit), .port_ibf_bit(port_ibf_bit),
    .ibf(ibf), .obf(obf), .dack_done(ev_dack_done), .dma_mode(dma_mode),
    .pin_obf(pin_obf), .pin_ibf(pin_ibf), .pin_drq(pin_drq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibuf_q <= '0;
      obuf_q <= '0;
    end else begin
      if (ev_wr_done)  ibuf_q <= wr_byte;
      if (cpu_obuf_wr) obuf_q <= cpu_obuf_data;
    end
  end

  assign status        = {user, hb_low(f1, f0, ibf, obf)};
  assign cpu_ibuf_data = ibuf_q;
  assign host_doe      = ev_rd_act;
  assign host_dout     = host_a0 ? status : obuf_q;

  AST_DOE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> !host_rd_n); // R5
  AST_WRITE_LANDS_IN_IBUF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_done |=> (cpu_ibuf_data == $past(wr_byte))); // R3
endmodule

// File: tb/hb_host_buffer_bench.sv
`timescale 1ns/1ps
module hb_host_buffer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, dack_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, ibuf_o, status;
  logic doe, p_obf_o, p_ibf_o, p_drq_o;
  logic ibuf_rd = 0, obuf_wr = 0, sts_ld = 0, f0_wr = 0, f0_val = 0, f1_wr = 0, f1_val = 0;
  logic flags_en = 0, dma_en = 0, drq_set = 0, lat_obf = 0, lat_ibf = 0;
  logic [7:0] obuf_in = 8'h00;
  logic [3:0] user_in = 4'h0;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_host_buffer u_hb_host_buffer (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_a0(a0), .host_dack_n(dack_n), .host_din(din), .host_dout(dout), .host_doe(doe),
    .cpu_ibuf_rd(ibuf_rd), .cpu_ibuf_data(ibuf_o), .cpu_obuf_wr(obuf_wr),
    .cpu_obuf_data(obuf_in), .cpu_sts_ld(sts_ld), .cpu_sts_user(user_in),
    .cpu_f0_wr(f0_wr), .cpu_f0_val(f0_val), .cpu_f1_wr(f1_wr), .cpu_f1_val(f1_val),
    .cpu_flags_en(flags_en), .cpu_dma_en(dma_en), .cpu_drq_set(drq_set),
    .port_obf_bit(lat_obf), .port_ibf_bit(lat_ibf),
    .pin_obf(p_obf_o), .pin_ibf(p_ibf_o), .pin_drq(p_drq_o), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ibuf, m_obuf, m_user, m_f1, m_f0, m_ibf, m_obf, m_flags, m_dma, m_drq;
  int pv_rd, pv_wr, pv_ra0, pv_wa0, pv_wd, pv_dk;
  int held[$];
  int now_q[$];
  bit s_sel, s_rd, s_wr, s_lk, s_rend, s_wend, s_dk;

  task automatic apply_op(input int c);
    case (c >> 8)
      1: m_ibf = 0;
      2: m_obf = 1;
      3: m_user = c & 15;
      4: m_f0 = c & 1;
      5: m_f1 = c & 1;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ibuf = 0; m_obuf = 0; m_user = 0; m_f1 = 0; m_f0 = 0; m_ibf = 0; m_obf = 0;
      m_flags = 0; m_dma = 0; m_drq = 0;
      pv_rd = 0; pv_wr = 0; pv_ra0 = 0; pv_wa0 = 0; pv_wd = 0; pv_dk = 0;
      held.delete();
    end else begin
      s_dk   = (m_dma != 0) && !dack_n;
      s_sel  = !cs_n || s_dk;
      s_rd   = s_sel && !rd_n;
      s_wr   = s_sel && !wr_n;
      s_lk   = s_rd && a0;
      s_rend = (pv_rd != 0) && !s_rd;
      s_wend = (pv_wr != 0) && !s_wr;
      now_q.delete();
      if (ibuf_rd) now_q.push_back(1 << 8);
      if (obuf_wr) now_q.push_back(2 << 8);
      if (sts_ld)  now_q.push_back((3 << 8) | int'(user_in));
      if (f0_wr)   now_q.push_back((4 << 8) | int'(f0_val));
      if (f1_wr)   now_q.push_back((5 << 8) | int'(f1_val));
      if (obuf_wr) m_obuf = obuf_in;
      if (s_lk) begin
        foreach (now_q[i]) held.push_back(now_q[i]);
      end else begin
        if (s_rend && pv_ra0 == 0) m_obf = 0;
        while (held.size() > 0) apply_op(held.pop_front());
        foreach (now_q[i]) apply_op(now_q[i]);
      end
      if (s_wend) begin m_ibuf = pv_wd; m_ibf = 1; m_f1 = pv_wa0; end
      if (dma_en) m_drq = 0;
      else if (m_dma != 0 && drq_set) m_drq = 1;
      else if ((s_rend || s_wend) && pv_dk != 0) m_drq = 0;
      if (dma_en) m_dma = 1;
      if (flags_en) m_flags = 1;
      pv_rd = s_rd; pv_wr = s_wr;
      if (s_rd) pv_ra0 = a0;
      if (s_wr) begin pv_wa0 = a0; pv_wd = din; end
      if (s_rd || s_wr) pv_dk = s_dk;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 user bits", status[7:4], m_user);
      chk("R3 F1", status[3], m_f1);
      chk("R7 F0", status[2], m_f0);
      chk("R3 IBF", status[1], m_ibf);
      chk("R4 OBF", status[0], m_obf);
      chk("R3 input buffer", ibuf_o, m_ibuf);
      chk("R5 output enable", doe, (!cs_n || (m_dma != 0 && !dack_n)) && !rd_n);
      if (doe)
        chk("R5 read data", dout,
            a0 ? ((m_user << 4) | (m_f1 << 3) | (m_f0 << 2) | (m_ibf << 1) | m_obf) : m_obuf);
      chk("R8 OBF pin", p_obf_o, m_flags != 0 && lat_obf && m_obf != 0);
      chk("R8 IBF pin", p_ibf_o, m_flags != 0 && lat_ibf && m_ibf == 0);
      chk("R9 DRQ pin", p_drq_o, m_drq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic host_write(input logic cmd, input logic [7:0] b, input logic use_dack);
    a0 = cmd; din = b; wr_n = 1'b0;
    if (use_dack) dack_n = 1'b0; else cs_n = 1'b0;
    tick();
    wr_n = 1'b1; cs_n = 1'b1; dack_n = 1'b1;
    tick();
  endtask

  task automatic core_pulse_clear();
    ibuf_rd = 0; obuf_wr = 0; sts_ld = 0; f0_wr = 0; f1_wr = 0;
    flags_en = 0; dma_en = 0; drq_set = 0;
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 status", status, 0); chk("R1 ibuf", ibuf_o, 0);
    chk("R1 doe", doe, 0); chk("R1 pins", {p_obf_o, p_ibf_o, p_drq_o}, 0);
    rst_n = 1'b1;
    tick();

    // R11 functions off: latches high, DACK ignored
    lat_obf = 1; lat_ibf = 1;
    tick();
    chk("R11 ibf pin off", p_ibf_o, 0);
    host_write(1'b0, 8'h77, 1'b1);
    chk("R11 DACK ignored ibf", status[1], 0);
    chk("R11 DACK ignored ibuf", ibuf_o, 0);

    // R3 data write, trailing edge
    a0 = 0; din = 8'h5A; cs_n = 0; wr_n = 0;
    tick();
    chk("R3 no IBF during strobe", status[1], 0);
    wr_n = 1; cs_n = 1;
    tick();
    chk("R3 IBF after write", status[1], 1);
    chk("R3 F1 data", status[3], 0);
    chk("R3 byte", ibuf_o, 8'h5A);
    host_write(1'b1, 8'hC3, 1'b0);
    chk("R3 F1 command", status[3], 1);
    chk("R3 command byte", ibuf_o, 8'hC3);

    // R4 core consumes, posts
    ibuf_rd = 1; tick(); core_pulse_clear(); tick();
    chk("R4 IBF cleared", status[1], 0);
    obuf_in = 8'h96; obuf_wr = 1; tick(); core_pulse_clear(); tick();
    chk("R4 OBF set", status[0], 1);

    // R5 status read clears nothing, data read clears OBF
    a0 = 1; cs_n = 0; rd_n = 0; tick();
    chk("R5 status on bus", dout, status);
    rd_n = 1; cs_n = 1; tick();
    chk("R5 status read keeps OBF", status[0], 1);
    a0 = 0; cs_n = 0; rd_n = 0; tick();
    chk("R5 data on bus", dout, 8'h96);
    chk("R5 OBF held during read", status[0], 1);
    rd_n = 1; cs_n = 1; tick();
    chk("R5 OBF cleared", status[0], 0);
    chk("R5 doe released", doe, 0);

    // R2 user status load
    user_in = 4'hA; sts_ld = 1; tick(); core_pulse_clear(); tick();
    chk("R2 user nibble", status, 8'hA8);

    // R7 F0 / F1
    f0_wr = 1; f0_val = 1; f1_wr = 1; f1_val = 0; tick(); core_pulse_clear(); tick();
    chk("R7 F0 set F1 cleared", status[3:2], 2'b01);

    // R6 lockout during status read
    a0 = 1; cs_n = 0; rd_n = 0;
    obuf_in = 8'h11; obuf_wr = 1; user_in = 4'h3; sts_ld = 1; f0_wr = 1; f0_val = 0;
    tick(); core_pulse_clear();
    user_in = 4'h5; sts_ld = 1;
    tick(); core_pulse_clear();
    chk("R6 status frozen", status, 8'hA4);
    rd_n = 1; cs_n = 1; tick();
    chk("R6 deferred applied", status, 8'h51);

    // R4 same-cycle: core write wins over end of data read
    a0 = 0; cs_n = 0; rd_n = 0; tick();
    chk("R5 deferred byte", dout, 8'h11);
    rd_n = 1; cs_n = 1; obuf_in = 8'h22; obuf_wr = 1; tick(); core_pulse_clear();
    chk("R4 OBF priority", status[0], 1);
    // R4 same-cycle: host write end wins over core read
    a0 = 0; din = 8'h3C; cs_n = 0; wr_n = 0; tick();
    wr_n = 1; cs_n = 1; ibuf_rd = 1; tick(); core_pulse_clear();
    chk("R4 IBF priority", status[1], 1);

    // R8 flag pins
    flags_en = 1; tick(); core_pulse_clear();
    chk("R8 OBF pin on", p_obf_o, 1);
    chk("R8 IBF pin full", p_ibf_o, 0);
    ibuf_rd = 1; tick(); core_pulse_clear();
    chk("R8 IBF pin ready", p_ibf_o, 1);
    lat_ibf = 0; lat_obf = 0; tick();
    chk("R8 pins gated", {p_obf_o, p_ibf_o}, 0);

    // R9 / R10 DMA
    drq_set = 1; tick(); core_pulse_clear();
    chk("R9 set ignored before enable", p_drq_o, 0);
    dma_en = 1; tick(); core_pulse_clear();
    drq_set = 1; tick(); core_pulse_clear();
    chk("R9 DRQ raised", p_drq_o, 1);
    host_write(1'b0, 8'hE1, 1'b1);
    chk("R10 DACK write lands", ibuf_o, 8'hE1);
    chk("R9 DRQ dropped by DACK", p_drq_o, 0);
    drq_set = 1; tick(); core_pulse_clear();
    dack_n = 0; rd_n = 0; a0 = 0; tick();
    chk("R10 DACK read", dout, 8'h22);
    rd_n = 1; dack_n = 1; tick();
    chk("R9 DRQ dropped by DACK read", p_drq_o, 0);
    drq_set = 1; tick(); core_pulse_clear();
    dma_en = 1; drq_set = 1; tick(); core_pulse_clear();
    chk("R9 re-enable clears", p_drq_o, 0);

    repeat (3) tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule